// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block produces the address of the next instruction to fetch, one address per clock. Each cycle it is given the decoded class of the instruction that sits at the current fetch address, together with a branch target, a flag saying whether that instruction's condition holds, and, for a loop-start instruction, the address of the loop's last instruction and its iteration count. From these it picks the next address. The choices are the following address, a jump target, a subroutine entry, a return address, or the first address of an active loop.

Three kinds of state live inside the block. A return-address stack serves calls and returns. A loop stack holds, in each entry, the loop's first address, its last address and its remaining count. Whenever the fetch address reaches the last address of the innermost loop, the sequencer either goes back to the loop's first address and decrements the count, or it retires the loop and falls through. Both happen with no extra cycle and with no branch instruction at the end of the loop. Overflow and underflow of either stack are reported on sticky flags.

Top module: `zol_sequencer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, fetch_addr_o is 0, all four flags are 0, and both stacks are empty.
- R2: Instruction classes on op_i are 0 plain, 1 jump, 2 call, 3 return, 4 loop start, 5 loop break. Codes 6 and 7 behave as plain. A plain instruction that is not at the innermost loop's end moves fetch_addr_o to the current address plus one, wrapping from 3FFF to 0000.
- R3: A jump with cond_i=1 sets the next fetch address to target_i. With cond_i=0 it behaves as plain.
- R4: A call with cond_i=1 pushes the current address plus one and goes to target_i. With cond_i=0 it behaves as plain and pushes nothing.
- R5: A return with cond_i=1 pops the return-address stack and goes to the popped address. On an empty stack it sets pc_unf_o and goes to the current address plus one. With cond_i=0 it behaves as plain.
- R6: A loop start pushes a loop entry made of first address = current address plus one, end address = loop_end_i and count = loop_cnt_i, then moves to the next address. It never ends a loop itself, even when it sits at the current loop's end address.
- R7: A non-branching instruction whose address equals the innermost loop's end address, where that loop's count is above 1, sends fetch_addr_o to the loop's first address and decrements the count in the same cycle.
- R8: In the same position with a count of 1 or 0, the loop entry is popped and execution falls through to the next address. Only the innermost loop is compared in that cycle.
- R9: A taken jump, call or return at a loop's end address has priority: the loop entry and its count stay unchanged.
- R10: A loop break pops the innermost loop and moves to the next address. On an empty loop stack it sets lp_unf_o.
- R11: The return-address stack holds 16 entries. A call when it is full sets pc_ovf_o, drops the pushed value and still goes to target_i.
- R12: The loop stack holds 4 entries. A loop start when it is full sets lp_ovf_o and drops the new entry.
- R13: Once set, each flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Decoded class of the instruction at fetch_addr_o |
| cond_i | input | 1 | Condition of a jump, call or return is true |
| target_i | input | 14 | Jump or call target |
| loop_end_i | input | 14 | End address for a loop start |
| loop_cnt_i | input | 14 | Iteration count for a loop start |
| fetch_addr_o | output | 14 | Current fetch address |
| pc_ovf_o | output | 1 | Sticky: return-address stack overflow |
| pc_unf_o | output | 1 | Sticky: return-address stack underflow |
| lp_ovf_o | output | 1 | Sticky: loop stack overflow |
| lp_unf_o | output | 1 | Sticky: loop stack underflow |

## Verification
The hardest condition to reach is the fetch address landing exactly on the innermost loop's end address while other events happen at the same time: nested loops that share one end address, a taken branch at the end address, or a loop start placed at an outer loop's end. Random jumps rarely land there. The stimulus therefore places every loop end only one to six words ahead of the loop start and keeps branch targets within a narrow window. Directed sequences then build each of these coincidences on purpose, and a model in the bench tracks both stacks.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_LOOP  = 3'd4,
    OP_BREAK = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;
endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full,
  output logic         ovf,
  output logic         unf
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [CNTW-1:0] fill;
  logic [CNTW-1:0] fill_m1;
  logic [IW-1:0]   wr_idx;
  logic [IW-1:0]   rd_idx;
  logic            do_push;
  logic            do_pop;
  logic            do_upd;

  assign fill_m1 = fill - 1'b1;
  assign wr_idx  = fill[IW-1:0];
  assign rd_idx  = fill_m1[IW-1:0];
  assign empty   = (fill == '0);
  assign full    = (fill == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;
  assign do_upd  = upd && !empty && !push && !pop;
  assign ovf     = push && full;
  assign unf     = pop && empty;
  assign top     = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (do_push) begin
      fill <= fill + 1'b1;
    end else if (do_pop) begin
      fill <= fill_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_idx] <= din;
    end else if (do_upd) begin
      mem[rd_idx] <= upd_val;
    end
  end

  // R11 / R12: occupancy never exceeds the depth
  assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNTW'(DEPTH));

  // R11 / R12: a push into a full stack is dropped
  assert_full_push_dropped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (fill == $past(fill)));
endmodule

// File: rtl/zol_next.sv
module zol_next
  import zol_pkg::*;
#(
  parameter int AW = 14,
  parameter int CW = 14
) (
  input  op_e          op,
  input  logic         cond,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] ret_addr,
  input  logic         pc_empty,
  input  logic         lp_empty,
  input  logic [AW-1:0] lp_first,
  input  logic [AW-1:0] lp_last,
  input  logic [CW-1:0] lp_count,
  output logic [AW-1:0] next_addr,
  output logic         jump_taken,
  output logic         call_taken,
  output logic         ret_taken,
  output logic         end_hit,
  output logic         loop_back,
  output logic         loop_exit,
  output logic         lp_push,
  output logic         lp_pop,
  output logic [CW-1:0] count_next
);
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic keep_looping(input logic [CW-1:0] c);
    return c > CW'(1);
  endfunction

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  logic any_taken;
  logic no_end_check;

  assign jump_taken   = (op == OP_JUMP) && cond;
  assign call_taken   = (op == OP_CALL) && cond;
  assign ret_taken    = (op == OP_RET)  && cond;
  assign any_taken    = jump_taken || call_taken || ret_taken;
  assign no_end_check = any_taken || (op == OP_LOOP) || (op == OP_BREAK);
  assign end_hit      = !no_end_check && !lp_empty && (pc == lp_last);
  assign loop_back    = end_hit && keep_looping(lp_count);
  assign loop_exit    = end_hit && !keep_looping(lp_count);
  assign lp_push      = (op == OP_LOOP);
  assign lp_pop       = loop_exit || (op == OP_BREAK);
  assign count_next   = count_down(lp_count);

  always_comb begin
    if (jump_taken || call_taken) begin
      next_addr = target;
    end else if (ret_taken) begin
      next_addr = pc_empty ? step_addr(pc) : ret_addr;
    end else if (loop_back) begin
      next_addr = lp_first;
    end else begin
      next_addr = step_addr(pc);
    end
  end
endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_pkg::*;
#(
  parameter int AW        = 14,
  parameter int CW        = 14,
  parameter int PC_DEPTH  = 16,
  parameter int LP_DEPTH  = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic          cond_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] loop_end_i,
  input  logic [CW-1:0] loop_cnt_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          pc_ovf_o,
  output logic          pc_unf_o,
  output logic          lp_ovf_o,
  output logic          lp_unf_o
);
  localparam int LW = 2 * AW + CW;

  op_e           op;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] ret_addr;
  logic          pc_empty, pc_full, pc_ovf, pc_unf;
  logic [LW-1:0] lp_top, lp_din, lp_upd_val;
  logic          lp_empty, lp_full, lp_ovf, lp_unf;
  logic [AW-1:0] lp_first, lp_last;
  logic [CW-1:0] lp_count, count_next;
  logic          jump_taken, call_taken, ret_taken;
  logic          end_hit, loop_back, loop_exit, lp_push, lp_pop;
  logic          pc_ovf_q, pc_unf_q, lp_ovf_q, lp_unf_q;

  assign op       = op_e'(op_i);
  assign lp_first = lp_top[LW-1 -: AW];
  assign lp_last  = lp_top[CW +: AW];
  assign lp_count = lp_top[CW-1:0];
  assign lp_din   = {pc_q + 1'b1, loop_end_i, loop_cnt_i};
  assign lp_upd_val = {lp_first, lp_last, count_next};

  zol_stack #(.W(AW), .DEPTH(PC_DEPTH)) u_pc_stack (
    .clk(clk), .rst_n(rst_n),
    .push(call_taken), .pop(ret_taken), .upd(1'b0),
    .din(pc_q + 1'b1), .upd_val('0),
    .top(ret_addr), .empty(pc_empty), .full(pc_full),
    .ovf(pc_ovf), .unf(pc_unf)
  );

  zol_stack #(.W(LW), .DEPTH(LP_DEPTH)) u_loop_stack (
    .clk(clk), .rst_n(rst_n),
    .push(lp_push), .pop(lp_pop), .upd(loop_back),
    .din(lp_din), .upd_val(lp_upd_val),
    .top(lp_top), .empty(lp_empty), .full(lp_full),
    .ovf(lp_ovf), .unf(lp_unf)
  );

  zol_next #(.AW(AW), .CW(CW)) u_next (
    .op(op), .cond(cond_i), .pc(pc_q), .target(target_i),
    .ret_addr(ret_addr), .pc_empty(pc_empty),
    .lp_empty(lp_empty), .lp_first(lp_first), .lp_last(lp_last),
    .lp_count(lp_count), .next_addr(next_addr),
    .jump_taken(jump_taken), .call_taken(call_taken), .ret_taken(ret_taken),
    .end_hit(end_hit), .loop_back(loop_back), .loop_exit(loop_exit),
    .lp_push(lp_push), .lp_pop(lp_pop), .count_next(count_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_ADDR;
      pc_ovf_q <= 1'b0;
      pc_unf_q <= 1'b0;
      lp_ovf_q <= 1'b0;
      lp_unf_q <= 1'b0;
    end else begin
      pc_q     <= next_addr;
      pc_ovf_q <= pc_ovf_q | pc_ovf;
      pc_unf_q <= pc_unf_q | pc_unf;
      lp_ovf_q <= lp_ovf_q | lp_ovf;
      lp_unf_q <= lp_unf_q | lp_unf;
    end
  end

  assign fetch_addr_o = pc_q;
  assign pc_ovf_o     = pc_ovf_q;
  assign pc_unf_o     = pc_unf_q;
  assign lp_ovf_o     = lp_ovf_q;
  assign lp_unf_o     = lp_unf_q;

  assert_plain_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 && !end_hit) |=> (fetch_addr_o == $past(fetch_addr_o) + 1'b1));

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && cond_i) |=> (fetch_addr_o == $past(target_i)));

  assert_ret_empty_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && cond_i && pc_empty) |=> pc_unf_o);

  assert_loop_start_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |=> (fetch_addr_o == $past(fetch_addr_o) + 1'b1));

  assert_loop_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back |=> (fetch_addr_o == $past(lp_first)));

  assert_loop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> (fetch_addr_o == $past(fetch_addr_o) + 1'b1));

  assert_full_call_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (call_taken && pc_full) |=> pc_ovf_o);

  assert_full_loop_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_push && lp_full) |=> lp_ovf_o);

  assert_sticky_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ovf_o || pc_unf_o || lp_ovf_o || lp_unf_o) |=>
      (pc_ovf_o >= $past(pc_ovf_o) && pc_unf_o >= $past(pc_unf_o) &&
       lp_ovf_o >= $past(lp_ovf_o) && lp_unf_o >= $past(lp_unf_o)));
endmodule

// File: tb/zol_sequencer_tb.sv
`timescale 1ns/1ps
module zol_sequencer_tb;
  localparam int AW = 14;
  localparam int CW = 14;
  localparam int PCD = 16;
  localparam int LPD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op = 3'd0;
  logic          cond = 1'b0;
  logic [AW-1:0] tgt = '0;
  logic [AW-1:0] lend = '0;
  logic [CW-1:0] lcnt = '0;
  logic [AW-1:0] fetch;
  logic          pc_ovf, pc_unf, lp_ovf, lp_unf;

  zol_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .cond_i(cond), .target_i(tgt),
    .loop_end_i(lend), .loop_cnt_i(lcnt), .fetch_addr_o(fetch),
    .pc_ovf_o(pc_ovf), .pc_unf_o(pc_unf), .lp_ovf_o(lp_ovf), .lp_unf_o(lp_unf)
  );

  always #2.5 clk = ~clk;

  // reference model
  logic [AW-1:0] m_pc;
  logic [AW-1:0] m_ret [PCD];
  int            m_pn;
  logic [AW-1:0] m_first [LPD];
  logic [AW-1:0] m_last [LPD];
  logic [CW-1:0] m_cnt [LPD];
  int            m_ln;
  logic          m_povf, m_punf, m_lovf, m_lunf;
  string         tag;
  int            checks = 0;
  int            fails = 0;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] near(input logic [AW-1:0] a, input int span);
    return a + AW'($urandom % span);
  endfunction

  task automatic model_clear();
    m_pc = '0; m_pn = 0; m_ln = 0;
    m_povf = 0; m_punf = 0; m_lovf = 0; m_lunf = 0;
  endtask

  task automatic model_step(input logic [2:0] o, input logic c,
                            input logic [AW-1:0] t, input logic [AW-1:0] le,
                            input logic [CW-1:0] lc);
    logic taken;
    logic at_end;
    taken  = c && (o == 3'd1 || o == 3'd2 || o == 3'd3);
    at_end = (m_ln > 0) && (m_pc == m_last[m_ln-1]);
    if (taken && at_end) tag = "R9"; else tag = "R2";
    if (o == 3'd1 && c) begin
      if (!at_end) tag = "R3";
      m_pc = t;
    end else if (o == 3'd2 && c) begin
      if (!at_end) tag = "R4";
      if (m_pn == PCD) begin m_povf = 1; tag = "R11"; end
      else begin m_ret[m_pn] = inc(m_pc); m_pn++; end
      m_pc = t;
    end else if (o == 3'd3 && c) begin
      if (!at_end) tag = "R5";
      if (m_pn == 0) begin m_punf = 1; m_pc = inc(m_pc); end
      else begin m_pn--; m_pc = m_ret[m_pn]; end
    end else if (o == 3'd4) begin
      tag = "R6";
      if (m_ln == LPD) begin m_lovf = 1; tag = "R12"; end
      else begin
        m_first[m_ln] = inc(m_pc); m_last[m_ln] = le; m_cnt[m_ln] = lc; m_ln++;
      end
      m_pc = inc(m_pc);
    end else if (o == 3'd5) begin
      tag = "R10";
      if (m_ln == 0) m_lunf = 1; else m_ln--;
      m_pc = inc(m_pc);
    end else if (at_end) begin
      if (m_cnt[m_ln-1] > 1) begin
        tag = "R7";
        m_cnt[m_ln-1] = m_cnt[m_ln-1] - 1'b1;
        m_pc = m_first[m_ln-1];
      end else begin
        tag = "R8";
        m_ln--;
        m_pc = inc(m_pc);
      end
    end else begin
      if (o == 3'd1) tag = "R3";
      m_pc = inc(m_pc);
    end
  endtask

  task automatic chk(input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(tag, "fetch_addr", 32'(fetch), 32'(m_pc));
    chk("R11", "pc_ovf", 32'(pc_ovf), 32'(m_povf));
    chk("R5", "pc_unf", 32'(pc_unf), 32'(m_punf));
    chk("R12", "lp_ovf", 32'(lp_ovf), 32'(m_lovf));
    chk("R10", "lp_unf", 32'(lp_unf), 32'(m_lunf));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [2:0] o, input logic c, input logic [AW-1:0] t,
                      input logic [AW-1:0] le, input logic [CW-1:0] lc);
    op = o; cond = c; tgt = t; lend = le; lcnt = lc;
    model_step(o, c, t, le, lc);
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic plain(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 1'b0, '0, '0, '0);
  endtask

  task automatic do_reset();
    op = 3'd0; cond = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 and R13: reset clears address and every flag
    chk("R1", "fetch_addr in reset", 32'(fetch), 32'd0);
    chk("R13", "flags in reset", {28'd0, pc_ovf, pc_unf, lp_ovf, lp_unf}, 32'd0);
    model_clear();
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] p;
    int r;
    void'($urandom(32'd24681));
    model_clear();
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    do_reset();

    // R1: both stacks empty after reset -> underflow on return and break
    step(3'd3, 1'b1, '0, '0, '0);
    step(3'd5, 1'b0, '0, '0, '0);
    plain(2);
    do_reset();

    // R2/R3/R4/R5: untaken branches fall through; codes 6 and 7 are plain
    step(3'd1, 1'b0, 14'h100, '0, '0);
    step(3'd2, 1'b0, 14'h100, '0, '0);
    step(3'd3, 1'b0, '0, '0, '0);
    step(3'd6, 1'b1, 14'h200, '0, '0);
    step(3'd7, 1'b1, 14'h200, '0, '0);
    // R4/R5: call then return
    step(3'd2, 1'b1, 14'h040, '0, '0);
    plain(3);
    step(3'd3, 1'b1, '0, '0, '0);

    // R7/R8: simple loop of three iterations
    p = m_pc;
    step(3'd4, 1'b0, '0, p + 14'd2, 14'd3);
    plain(10);
    // count 0 runs the body once
    p = m_pc;
    step(3'd4, 1'b0, '0, p + 14'd1, 14'd0);
    plain(4);

    // R8: nested loops sharing one end address
    p = m_pc;
    step(3'd4, 1'b0, '0, p + 14'd3, 14'd2);
    step(3'd4, 1'b0, '0, p + 14'd3, 14'd2);
    plain(14);

    // R9: taken jump at a loop end keeps the loop
    p = m_pc;
    step(3'd4, 1'b0, '0, p + 14'd1, 14'd5);
    step(3'd1, 1'b1, p + 14'd1, '0, '0);
    step(3'd1, 1'b1, p + 14'd1, '0, '0);
    step(3'd5, 1'b0, '0, '0, '0);

    // R6: loop start at the outer loop's end does not close it
    p = m_pc;
    step(3'd4, 1'b0, '0, p + 14'd1, 14'd2);
    step(3'd4, 1'b0, '0, p + 14'd4, 14'd1);
    plain(12);

    // R11: 17 calls, then 17 returns
    for (int i = 0; i < PCD + 1; i++) step(3'd2, 1'b1, m_pc + 14'd3, '0, '0);
    for (int i = 0; i < PCD + 1; i++) step(3'd3, 1'b1, '0, '0, '0);
    // R12: five loop starts, then five breaks
    for (int i = 0; i < LPD + 1; i++) step(3'd4, 1'b0, '0, 14'h3000, 14'd2);
    for (int i = 0; i < LPD + 1; i++) step(3'd5, 1'b0, '0, '0, '0);
    // R13: flags stay set
    plain(3);

    // R2: address wrap
    step(3'd1, 1'b1, 14'h3FFE, '0, '0);
    plain(3);

    // random traffic near loop ends
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 499) do_reset();
      r = $urandom % 100;
      if (r < 40)      step(3'($urandom % 2 ? 0 : 6), 1'b0, '0, '0, '0);
      else if (r < 50) step(3'd1, 1'($urandom % 2), near(m_pc - 14'd8, 16), '0, '0);
      else if (r < 62) step(3'd2, 1'($urandom % 2), near(m_pc - 14'd8, 16), '0, '0);
      else if (r < 74) step(3'd3, 1'($urandom % 2), '0, '0, '0);
      else if (r < 90) step(3'd4, 1'b0, '0, near(m_pc + 14'd1, 6), CW'($urandom % 5));
      else             step(3'd5, 1'b0, '0, '0, '0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule